// File: doc/BRIEF.md
# PC-Relative Capability Literal Load Unit

This unit executes one instruction: a literal load of a capability, with the address taken relative to the program-counter capability. When it is idle, it takes a 32-bit instruction word. If the word matches the opcode, the unit takes the signed immediate, scales it by 16 and adds it to the program-counter capability's address. It then rounds the sum down to a 16-byte boundary.

The unit checks the access against the program-counter capability's tag, seal, load permission and bounds. If the check passes, it issues one 129-bit capability read. When the response arrives, the unit writes the returned value to one of 32 capability registers. It strips the tag on the way if the authorising capability lacks the load-capability permission.

A failed check, or an issue while capabilities are disabled, produces a one-cycle fault pulse with a code for an external trap unit. After a fault the unit does not touch memory or the register file.

Top module: `pcc_capload_unit`

## Requirements
- R1: An instruction is accepted only when `issue_valid` is high, the unit is idle, and bits [31:22] equal 10'b1000001000. The immediate is bits [21:5] and the destination index is bits [4:0]. Any other word is ignored: no fault, no memory request and no register write follow it.
- R2: If `cap_en` is low when a matching instruction is issued, `fault_valid` pulses for one cycle in the cycle after the issue edge with `fault_code` 1. `busy` stays low and no memory request is made.
- R3: The request address is the program-counter capability address plus the sign-extended immediate times 16, with the low 4 bits then cleared.
- R4: The access check reports the first failure in this priority order: tag clear (code 2), sealed (code 3), load permission bit 0 clear (code 4), out of bounds (code 5). A fault pulses `fault_valid` in the second cycle after issue, and no memory request or register write follows it.
- R5: The access is in bounds only when the address is at least `pcc_base` and the address plus 16 is at most `pcc_top`. The top limit is exclusive, so reaching it exactly is allowed.
- R6: A passing check raises `mem_req` for exactly one cycle, in the second cycle after issue.
- R7: The tag of the written value (bit 128) is the response tag ANDed with permission bit 3 (load-capability). Bits [127:0] are passed through unchanged.
- R8: `rf_we` pulses for one cycle, in the cycle after the one in which `mem_rsp_valid` was sampled high. During that pulse `rf_idx` equals instruction bits [4:0].
- R9: After reset, `busy`, `mem_req`, `rf_we` and `fault_valid` are all low. `busy` is high from the cycle after an accepted issue until the write or fault completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction word present |
| issue_insn | input | 32 | Instruction word |
| cap_en | input | 1 | Capabilities enabled |
| pcc_addr | input | 64 | Program-counter capability address |
| pcc_base | input | 64 | Lower bound, inclusive |
| pcc_top | input | 64 | Upper bound, exclusive |
| pcc_perms | input | 4 | Permissions: bit0 load, bit1 store, bit2 execute, bit3 load-capability |
| pcc_tag | input | 1 | Program-counter capability valid tag |
| pcc_sealed | input | 1 | Program-counter capability is sealed |
| mem_req | output | 1 | Capability read request |
| mem_addr | output | 64 | Read address, 16-byte aligned |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | 129 | Response: tag in bit 128, data below |
| rf_we | output | 1 | Register write strobe |
| rf_idx | output | 5 | Destination register index |
| rf_data | output | 129 | Value to write |
| fault_valid | output | 1 | Fault pulse |
| fault_code | output | 3 | Fault kind: 1 disabled, 2 tag, 3 seal, 4 permission, 5 bounds |
| busy | output | 1 | Unit is executing |

## Verification
Counting from the clock edge that samples the issue, the outputs are due at fixed cycles. A disabled fault appears one cycle later, and a check fault or the memory request two cycles later. The register write appears one cycle after the edge that sampled the response. The bench steps one cycle at a time from the issue edge and records the cycle number at which each output appears. It samples on falling edges, drives the memory response a chosen latency after the request, and compares each recorded cycle against these counts as well as checking the values.

// File: rtl/pcc_capload_pkg.sv
package pcc_capload_pkg;
  localparam logic [9:0] LIT_CAP_OPCODE = 10'b1000001000;
  localparam int PERM_LOAD    = 0;
  localparam int PERM_STORE   = 1;
  localparam int PERM_EXEC    = 2;
  localparam int PERM_LOADCAP = 3;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_DISABLED = 3'd1,
    FLT_TAG      = 3'd2,
    FLT_SEAL     = 3'd3,
    FLT_PERM     = 3'd4,
    FLT_BOUNDS   = 3'd5
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_REQ, ST_WAIT, ST_WB
  } ld_state_e;
endpackage

// File: rtl/pcc_capload_decode.sv
module pcc_capload_decode
  import pcc_capload_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IMM_W  = 17,
  parameter int IDX_W  = 5,
  parameter int SHIFT  = 4
) (
  input  logic [31:0]       insn,
  output logic              match,
  output logic [IDX_W-1:0]  rd,
  output logic [ADDR_W-1:0] offset
);
  localparam int OPC_LSB = IMM_W + IDX_W;
  localparam int EXT_W   = ADDR_W - IMM_W - SHIFT;

  logic [IMM_W-1:0] imm;

  always_comb begin
    match  = (insn[31:OPC_LSB] == LIT_CAP_OPCODE);
    imm    = insn[OPC_LSB-1:IDX_W];
    rd     = insn[IDX_W-1:0];
    offset = {{EXT_W{imm[IMM_W-1]}}, imm, {SHIFT{1'b0}}};
  end
endmodule

// File: rtl/pcc_capload_check.sv
module pcc_capload_check
  import pcc_capload_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int PERM_W    = 4,
  parameter int CAP_BYTES = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] top,
  input  logic [PERM_W-1:0] perms,
  input  logic              tag,
  input  logic              sealed,
  output fault_e            fault
);
  logic [ADDR_W:0] end_addr;
  logic            in_bounds;

  always_comb begin
    end_addr  = {1'b0, addr} + (ADDR_W+1)'(CAP_BYTES);
    in_bounds = (addr >= base) && (end_addr <= {1'b0, top});
    if (!tag)                    fault = FLT_TAG;
    else if (sealed)             fault = FLT_SEAL;
    else if (!perms[PERM_LOAD])  fault = FLT_PERM;
    else if (!in_bounds)         fault = FLT_BOUNDS;
    else                         fault = FLT_NONE;
  end
endmodule

// File: rtl/pcc_capload_unit.sv
module pcc_capload_unit
  import pcc_capload_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int CAP_W    = 129,
  parameter int IMM_W    = 17,
  parameter int IDX_W    = 5,
  parameter int PERM_W   = 4,
  parameter int ALIGN_LG = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [31:0]       issue_insn,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] pcc_addr,
  input  logic [ADDR_W-1:0] pcc_base,
  input  logic [ADDR_W-1:0] pcc_top,
  input  logic [PERM_W-1:0] pcc_perms,
  input  logic              pcc_tag,
  input  logic              pcc_sealed,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [CAP_W-1:0]  mem_rsp_data,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_idx,
  output logic [CAP_W-1:0]  rf_data,
  output logic              fault_valid,
  output logic [2:0]        fault_code,
  output logic              busy
);
  localparam int CAP_BYTES = 1 << ALIGN_LG;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(CAP_BYTES - 1);

  ld_state_e         state;
  logic [ADDR_W-1:0] addr_q, base_q, top_q;
  logic [PERM_W-1:0] perm_q;
  logic              tag_q, sealed_q;
  logic [IDX_W-1:0]  rd_q;

  logic              dec_match;
  logic [IDX_W-1:0]  dec_rd;
  logic [ADDR_W-1:0] dec_off;
  fault_e            chk_fault;

  pcc_capload_decode #(
    .ADDR_W(ADDR_W), .IMM_W(IMM_W), .IDX_W(IDX_W), .SHIFT(ALIGN_LG)
  ) u_decode (
    .insn(issue_insn), .match(dec_match), .rd(dec_rd), .offset(dec_off)
  );

  pcc_capload_check #(
    .ADDR_W(ADDR_W), .PERM_W(PERM_W), .CAP_BYTES(CAP_BYTES)
  ) u_check (
    .addr(addr_q), .base(base_q), .top(top_q), .perms(perm_q),
    .tag(tag_q), .sealed(sealed_q), .fault(chk_fault)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      addr_q      <= '0;
      base_q      <= '0;
      top_q       <= '0;
      perm_q      <= '0;
      tag_q       <= 1'b0;
      sealed_q    <= 1'b0;
      rd_q        <= '0;
      rf_we       <= 1'b0;
      rf_data     <= '0;
      fault_valid <= 1'b0;
      fault_code  <= FLT_NONE;
    end else begin
      rf_we       <= 1'b0;
      fault_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (issue_valid && dec_match) begin
            if (!cap_en) begin
              fault_valid <= 1'b1;
              fault_code  <= FLT_DISABLED;
            end else begin
              addr_q   <= (pcc_addr + dec_off) & ALIGN_MASK;
              base_q   <= pcc_base;
              top_q    <= pcc_top;
              perm_q   <= pcc_perms;
              tag_q    <= pcc_tag;
              sealed_q <= pcc_sealed;
              rd_q     <= dec_rd;
              state    <= ST_CHECK;
            end
          end
        end
        ST_CHECK: begin
          if (chk_fault != FLT_NONE) begin
            fault_valid <= 1'b1;
            fault_code  <= chk_fault;
            state       <= ST_IDLE;
          end else begin
            state <= ST_REQ;
          end
        end
        ST_REQ: state <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            rf_data <= {mem_rsp_data[CAP_W-1] & perm_q[PERM_LOADCAP],
                        mem_rsp_data[CAP_W-2:0]};
            rf_we   <= 1'b1;
            state   <= ST_WB;
          end
        end
        ST_WB:   state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_req  = (state == ST_REQ);
  assign mem_addr = addr_q;
  assign rf_idx   = rd_q;
  assign busy     = (state != ST_IDLE);

  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R6
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[ALIGN_LG-1:0] == '0)); // R3
  AST_FAULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (!rf_we && !mem_req)); // R4
  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (rst)
    fault_valid |=> !fault_valid); // R2
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
    (fault_valid && fault_code == FLT_DISABLED) |-> !busy); // R2
  AST_TAG_SQUASH: assert property (@(posedge clk) disable iff (rst)
    (rf_we && !perm_q[PERM_LOADCAP]) |-> !rf_data[CAP_W-1]); // R7
  AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> !rf_we); // R8
  AST_BUSY_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    (mem_req || rf_we) |-> busy); // R9
endmodule

// File: tb/pcc_capload_unit_test.sv
`timescale 1ns/1ps
module pcc_capload_unit_test;
  typedef struct packed {
    logic [31:0] insn;
    logic [63:0] paddr;
    logic [63:0] base;
    logic [63:0] top;
    logic [3:0]  perms;
    logic        tag;
    logic        sealed;
    logic [3:0]  lat;
    logic [2:0]  xfault;
    logic [63:0] xaddr;
  } vec_t;

  function automatic logic [31:0] mk(input logic [16:0] imm, input logic [4:0] rd);
    return {10'b1000001000, imm, rd};
  endfunction

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{mk(17'h00001, 5'd3),  64'h1000, 64'h0,    64'h10000, 4'b1001, 1'b1, 1'b0, 4'd1, 3'd0, 64'h1010},
    '{mk(17'h1FFFF, 5'd31), 64'h1000, 64'h0,    64'h10000, 4'b1001, 1'b1, 1'b0, 4'd3, 3'd0, 64'h0FF0},
    '{mk(17'h00002, 5'd0),  64'h1007, 64'h0,    64'h10000, 4'b1111, 1'b1, 1'b0, 4'd2, 3'd0, 64'h1020},
    '{mk(17'h00001, 5'd7),  64'h1000, 64'h0,    64'h10000, 4'b0001, 1'b1, 1'b0, 4'd1, 3'd0, 64'h1010},
    '{mk(17'h00001, 5'd1),  64'h1000, 64'h0,    64'h10000, 4'b1001, 1'b0, 1'b0, 4'd1, 3'd2, 64'h0},
    '{mk(17'h00001, 5'd1),  64'h1000, 64'h0,    64'h10000, 4'b1001, 1'b1, 1'b1, 4'd1, 3'd3, 64'h0},
    '{mk(17'h00001, 5'd1),  64'h1000, 64'h0,    64'h10000, 4'b1000, 1'b1, 1'b0, 4'd1, 3'd4, 64'h0},
    '{mk(17'h00000, 5'd9),  64'hFFF8, 64'h0,    64'h10000, 4'b1001, 1'b1, 1'b0, 4'd1, 3'd0, 64'hFFF0},
    '{mk(17'h00001, 5'd9),  64'hFFF8, 64'h0,    64'h10000, 4'b1001, 1'b1, 1'b0, 4'd1, 3'd5, 64'h0},
    '{mk(17'h1FFFF, 5'd2),  64'h1000, 64'h1000, 64'h10000, 4'b1001, 1'b1, 1'b0, 4'd1, 3'd5, 64'h0},
    '{mk(17'h00001, 5'd2),  64'h1000, 64'h0,    64'h10000, 4'b0000, 1'b0, 1'b1, 4'd1, 3'd2, 64'h0}
  };

  logic         clk = 1'b0, rst = 1'b1;
  logic         issue_valid = 1'b0, cap_en = 1'b1;
  logic [31:0]  issue_insn = '0;
  logic [63:0]  pcc_addr = '0, pcc_base = '0, pcc_top = '0;
  logic [3:0]   pcc_perms = '0;
  logic         pcc_tag = 1'b0, pcc_sealed = 1'b0;
  logic         mem_req, mem_rsp_valid = 1'b0;
  logic [63:0]  mem_addr;
  logic [128:0] mem_rsp_data = '0;
  logic         rf_we, fault_valid, busy;
  logic [4:0]   rf_idx;
  logic [128:0] rf_data;
  logic [2:0]   fault_code;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pcc_capload_unit uut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_insn(issue_insn),
    .cap_en(cap_en), .pcc_addr(pcc_addr), .pcc_base(pcc_base), .pcc_top(pcc_top),
    .pcc_perms(pcc_perms), .pcc_tag(pcc_tag), .pcc_sealed(pcc_sealed),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data),
    .fault_valid(fault_valid), .fault_code(fault_code), .busy(busy)
  );

  task automatic chk(input logic ok, input string req, input logic [128:0] act,
                     input logic [128:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Steps cycle by cycle from the issue edge; k counts falling edges after it.
  task automatic run(input vec_t v, input logic en, input int id);
    int req_k = 0, req_n = 0, we_k = 0, flt_k = 0, busy1 = 0;
    logic [63:0]  got_addr = '0;
    logic [4:0]   got_idx = '0;
    logic [128:0] got_data = '0;
    logic [2:0]   got_flt = '0;
    logic [127:0] body = {64'hA5A5_0000_0000_0000 | 64'(id), 64'h5A5A_1234_5678_9ABC};
    logic [128:0] xdata = {v.perms[3], body};
    @(negedge clk);
    issue_valid = 1'b1; issue_insn = v.insn; cap_en = en;
    pcc_addr = v.paddr; pcc_base = v.base; pcc_top = v.top;
    pcc_perms = v.perms; pcc_tag = v.tag; pcc_sealed = v.sealed;
    for (int k = 1; k <= 24; k++) begin
      @(negedge clk);
      if (k == 1) begin issue_valid = 1'b0; busy1 = busy; end
      if (mem_req) begin req_n++; if (req_k == 0) begin req_k = k; got_addr = mem_addr; end end
      if (rf_we && we_k == 0) begin we_k = k; got_idx = rf_idx; got_data = rf_data; end
      if (fault_valid && flt_k == 0) begin flt_k = k; got_flt = fault_code; end
      mem_rsp_valid = (req_k > 0) && (k == req_k + int'(v.lat));
      mem_rsp_data  = {1'b1, body};
    end
    mem_rsp_valid = 1'b0;
    if (!en) begin
      chk(flt_k == 1, "R2 disabled fault cycle", 129'(flt_k), 129'd1);
      chk(got_flt == 3'd1, "R2 disabled code", 129'(got_flt), 129'd1);
      chk(busy1 == 0 && req_n == 0 && we_k == 0, "R2 no activity", 129'(req_n), 129'd0);
    end else if (v.xfault != 3'd0) begin
      chk(flt_k == 2, "R4 fault cycle", 129'(flt_k), 129'd2);
      chk(got_flt == v.xfault, "R4 R5 fault code", 129'(got_flt), 129'(v.xfault));
      chk(req_n == 0 && we_k == 0, "R4 no read or write", 129'(req_n + we_k), 129'd0);
    end else begin
      chk(busy1 == 1, "R9 busy after issue", 129'(busy1), 129'd1);
      chk(req_k == 2 && req_n == 1, "R6 request timing", 129'(req_k), 129'd2);
      chk(got_addr == v.xaddr, "R3 R5 address", 129'(got_addr), 129'(v.xaddr));
      chk(flt_k == 0, "R4 no fault", 129'(flt_k), 129'd0);
      chk(we_k == req_k + int'(v.lat) + 1, "R8 write timing", 129'(we_k),
          129'(req_k + int'(v.lat) + 1));
      chk(got_idx == v.insn[4:0], "R8 index", 129'(got_idx), 129'(v.insn[4:0]));
      chk(got_data == xdata, "R7 written value", got_data, xdata);
    end
    chk(busy == 1'b0, "R9 idle at end", 129'(busy), 129'd0);
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk(!busy && !mem_req && !rf_we && !fault_valid, "R9 reset outputs",
        129'({busy, mem_req, rf_we, fault_valid}), 129'd0);
    for (int i = 0; i < NV; i++) run(VEC[i], 1'b1, i);
    // R2: capabilities disabled
    run(VEC[0], 1'b0, 0);
    // R1: non-matching opcode is ignored
    begin
      int seen = 0;
      @(negedge clk);
      issue_valid = 1'b1; cap_en = 1'b1; issue_insn = {10'b1000001001, 17'h1, 5'd4};
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        issue_valid = 1'b0;
        if (busy || mem_req || rf_we || fault_valid) seen++;
      end
      chk(seen == 0, "R1 mismatched opcode ignored", 129'(seen), 129'd0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule